// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block gives a host a read-only byte window onto four serial NOR flash devices that share one single-bit SPI bus. The window address is split in two. The top two bits pick one of four 16 MiB slots, and each slot maps to one chip select. The low 24 bits become the address sent to that device. Each read that reaches a device runs a plain serial read: opcode 0x03, three address bytes with the most significant bit first, and then data bytes shifted in on one line. The serial clock comes straight from the bus clock, so there is no divider to program.

Two size inputs, both counted in 512 KiB units, limit how much of the window is live. A burst setting selects 16-byte line fills into a small buffer, and later reads to that line are answered from the buffer. A stall input holds off host reads while another agent owns the bus.

Top module: `spiwin_top`

## Requirements
- R1: The chip select used is `rdAddr[25:24]` (`csN[k]` low for slot k). The device receives the 8-bit opcode 0x03 and then the 24-bit offset `rdAddr[23:0]`, most significant bit first.
- R2: SPI mode 0. `sclk` is low whenever no chip select is active. Inside a transaction `sclk` toggles on every bus clock, so each bit takes two clocks. `mosi` changes only while `sclk` is low. Data bytes arrive most significant bit first.
- R3: A read is out of range when `rdAddr>>19 >= totalUnits` or `rdAddr[23:0]>>19 >= devUnits`. Such a read returns 0x00 with `rdReady` high in the cycle after acceptance, and no chip select goes low.
- R4: With `burstCfg == 3`, a read that misses fetches the 16 bytes of its 16-byte-aligned line in one transaction, with address `{rdAddr[23:4],4'h0}`, and returns the requested byte. `rdReady` rises 321 clocks after the accepting edge and is high for exactly one cycle.
- R5: With `burstCfg == 3`, a read to the same chip select and the same 16-byte line as the last completed fill is answered in the cycle after acceptance, with no chip select activity.
- R6: With `burstCfg != 3`, every in-range read runs its own 1-byte transaction, even if its line is buffered. `rdReady` rises 81 clocks after the accepting edge.
- R7: While `stallHost` is high, no new read is accepted and no chip select goes low. A held request proceeds after `stallHost` falls.
- R8: At most one `csN` bit is low at any time. After a transaction ends, all chip selects stay high for at least two clocks before the next one starts.
- R9: After reset, all `csN` bits are high, `sclk` and `rdReady` are low, and the line buffer is empty, so the first burst read is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the serial clock is derived from it |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddr | input | 26 | Window byte address, held until `rdReady` |
| rdReq | input | 1 | Read request level, dropped after `rdReady` |
| rdReady | output | 1 | One-cycle pulse; `rdData` is valid while it is high |
| rdData | output | 8 | Read byte |
| totalUnits | input | 8 | Live window size in 512 KiB units |
| devUnits | input | 6 | Live size per device in 512 KiB units |
| burstCfg | input | 2 | The value 3 selects 16-byte line fills |
| stallHost | input | 1 | Holds off acceptance of host reads |
| sclk | output | 1 | Serial clock |
| csN | output | 4 | Active-low chip selects |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |

## Verification
A wrong internal state shows up at the ports within one read. A bad line tag or valid bit turns a 1-cycle hit into a 321-cycle miss, or the reverse, and the bench sees this both in the measured latency and in the change in the transaction count. A shift or bit-count error moves the opcode or the address seen by the behavioural flash model, or corrupts the returned byte, as soon as that transaction completes. A decode error drives the wrong chip select, or returns zero where data is expected, in the very read that hits the bad range.

// File: rtl/spiwin_pkg.sv
package spiwin_pkg;
  localparam logic [7:0] OPCODE_READ = 8'h03;
  localparam logic [1:0] BURST_16    = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FIN, ST_RESP} winState_t;

  typedef struct packed {
    logic start;     // launch a flash transaction
    logic burst;     // launched transaction is a line fill
    logic step;      // serial clock falling: advance output shift
    logic capture;   // sample miso
    logic byteDone;  // a full data byte is assembled
    logic finish;    // transaction over, deliver data
    logic respHit;   // answer from the line buffer
    logic respZero;  // answer with zero (out of range)
  } dpStrobe_t;
endpackage

// File: rtl/spiwin_ctrl.sv
module spiwin_ctrl
  import spiwin_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int CMD_BITS   = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       stallHost,
  input  logic       burstMode,
  input  logic       inRange,
  input  logic       lineHit,
  output dpStrobe_t  strb,
  output logic       busSclk,
  output logic       csActive,
  output logic       rdReady
);
  localparam int BURST_BITS  = CMD_BITS + 8 * LINE_BYTES;
  localparam int SINGLE_BITS = CMD_BITS + 8;
  localparam int CNT_W       = $clog2(BURST_BITS + 1);

  winState_t        state;
  logic             ph;
  logic [CNT_W-1:0] bitCnt;
  logic             burstLat;
  logic             accept;
  logic             fallEdge;
  logic [CNT_W-1:0] lastBit;

  assign accept   = (state == ST_IDLE) && rdReq && !stallHost;
  assign fallEdge = (state == ST_SHIFT) && ph;
  assign lastBit  = burstLat ? CNT_W'(BURST_BITS - 1) : CNT_W'(SINGLE_BITS - 1);

  always_comb begin
    strb          = '0;
    strb.start    = accept && inRange && !(burstMode && lineHit);
    strb.burst    = burstMode;
    strb.respHit  = accept && inRange && burstMode && lineHit;
    strb.respZero = accept && !inRange;
    strb.step     = fallEdge;
    strb.capture  = fallEdge && (bitCnt >= CNT_W'(CMD_BITS));
    strb.byteDone = fallEdge && (bitCnt >= CNT_W'(CMD_BITS)) && (bitCnt[2:0] == 3'b111);
    strb.finish   = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ph       <= 1'b0;
      bitCnt   <= '0;
      burstLat <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.start) begin
            state    <= ST_SHIFT;
            ph       <= 1'b0;
            bitCnt   <= '0;
            burstLat <= burstMode;
          end else if (strb.respHit || strb.respZero) begin
            state <= ST_RESP;
          end
        end
        ST_SHIFT: begin
          ph <= ~ph;
          if (ph) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == lastBit) state <= ST_FIN;
          end
        end
        ST_FIN:  state <= ST_RESP;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busSclk  = ph;
  assign csActive = (state == ST_SHIFT);
  assign rdReady  = (state == ST_RESP);

  // R7: a stalled idle controller never launches a transaction
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && stallHost) |=> (state != ST_SHIFT));
  // R4: the response strobe lasts one cycle
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |=> !rdReady);
  // R2: serial clock idles low outside a transaction
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |-> !busSclk);
endmodule

// File: rtl/spiwin_dp.sv
module spiwin_dp
  import spiwin_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int SLOT_W     = 24,
  parameter int UNIT_SHIFT = 19,
  parameter int TOTAL_W    = 8,
  parameter int DEV_W      = 6,
  parameter int LINE_BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [TOTAL_W-1:0]       totalUnits,
  input  logic [DEV_W-1:0]         devUnits,
  input  logic                     miso,
  input  logic                     csActive,
  output logic                     inRange,
  output logic                     lineHit,
  output logic                     mosi,
  output logic [(2**(ADDR_W-SLOT_W))-1:0] csN,
  output logic [7:0]               rdData
);
  localparam int CS_W     = ADDR_W - SLOT_W;
  localparam int NUM_CS   = 2 ** CS_W;
  localparam int OFF_LSB  = $clog2(LINE_BYTES);
  localparam int CMD_BITS = 8 + SLOT_W;

  logic [ADDR_W-1:0]         reqAddr;
  logic [CMD_BITS-1:0]       outShift;
  logic [7:0]                inShift;
  logic [7:0]                lineMem [LINE_BYTES];
  logic [OFF_LSB-1:0]        byteIdx;
  logic [7:0]                singleByte;
  logic                      lineValid;
  logic [ADDR_W-OFF_LSB-1:0] lineTag;
  logic                      burstReg;
  logic [7:0]                newByte;
  logic [SLOT_W-1:0]         fillAddr;
  logic [CS_W-1:0]           reqCs;

  assign inRange  = (int'(rdAddr >> UNIT_SHIFT) < int'(totalUnits)) &&
                    (int'(rdAddr[SLOT_W-1:0] >> UNIT_SHIFT) < int'(devUnits));
  assign lineHit  = lineValid && (lineTag == rdAddr[ADDR_W-1:OFF_LSB]);
  assign newByte  = {inShift[6:0], miso};
  assign fillAddr = strb.burst ? {rdAddr[SLOT_W-1:OFF_LSB], OFF_LSB'(0)} : rdAddr[SLOT_W-1:0];
  assign reqCs    = reqAddr[ADDR_W-1:SLOT_W];
  assign mosi     = outShift[CMD_BITS-1];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(csActive && (reqCs == CS_W'(g)));
  end

  always_ff @(posedge clk) begin
    if (strb.byteDone && burstReg) lineMem[byteIdx] <= newByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr    <= '0;
      outShift   <= '0;
      inShift    <= '0;
      byteIdx    <= '0;
      singleByte <= '0;
      lineValid  <= 1'b0;
      lineTag    <= '0;
      burstReg   <= 1'b0;
      rdData     <= '0;
    end else begin
      if (strb.start) begin
        reqAddr  <= rdAddr;
        burstReg <= strb.burst;
        outShift <= {OPCODE_READ, fillAddr};
        byteIdx  <= '0;
        if (strb.burst) lineValid <= 1'b0;
      end
      if (strb.step)    outShift <= outShift << 1;
      if (strb.capture) inShift  <= newByte;
      if (strb.byteDone) begin
        byteIdx    <= byteIdx + 1'b1;
        singleByte <= newByte;
      end
      if (strb.finish) begin
        if (burstReg) begin
          lineValid <= 1'b1;
          lineTag   <= reqAddr[ADDR_W-1:OFF_LSB];
          rdData    <= lineMem[reqAddr[OFF_LSB-1:0]];
        end else begin
          rdData <= singleByte;
        end
      end
      if (strb.respHit)  rdData <= lineMem[rdAddr[OFF_LSB-1:0]];
      if (strb.respZero) rdData <= '0;
    end
  end

  // R8: never two devices selected together
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R8: selects stay high at least two clocks after a transaction
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) != '1 && csN == '1) |=> (csN == '1));
  // R3: out-of-range answer is zero
  assert_zero_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.respZero |=> (rdData == 8'h00));
  // R5: a buffer hit touches no chip select
  assert_hit_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.respHit |=> (csN == '1));
endmodule

// File: rtl/spiwin_top.sv
module spiwin_top
  import spiwin_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int SLOT_W     = 24,
  parameter int UNIT_SHIFT = 19,
  parameter int TOTAL_W    = 8,
  parameter int DEV_W      = 6,
  parameter int LINE_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic                 rdReq,
  output logic                 rdReady,
  output logic [7:0]           rdData,
  input  logic [TOTAL_W-1:0]   totalUnits,
  input  logic [DEV_W-1:0]     devUnits,
  input  logic [1:0]           burstCfg,
  input  logic                 stallHost,
  output logic                 sclk,
  output logic [(2**(ADDR_W-SLOT_W))-1:0] csN,
  output logic                 mosi,
  input  logic                 miso
);
  dpStrobe_t strb;
  logic      inRange;
  logic      lineHit;
  logic      csActive;

  spiwin_ctrl #(.LINE_BYTES(LINE_BYTES), .CMD_BITS(8 + SLOT_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdReq     (rdReq),
    .stallHost (stallHost),
    .burstMode (burstCfg == BURST_16),
    .inRange   (inRange),
    .lineHit   (lineHit),
    .strb      (strb),
    .busSclk   (sclk),
    .csActive  (csActive),
    .rdReady   (rdReady)
  );

  spiwin_dp #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .UNIT_SHIFT(UNIT_SHIFT),
    .TOTAL_W(TOTAL_W), .DEV_W(DEV_W), .LINE_BYTES(LINE_BYTES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdAddr     (rdAddr),
    .totalUnits (totalUnits),
    .devUnits   (devUnits),
    .miso       (miso),
    .csActive   (csActive),
    .inRange    (inRange),
    .lineHit    (lineHit),
    .mosi       (mosi),
    .csN        (csN),
    .rdData     (rdData)
  );
endmodule

// File: tb/test_spiwin_top.sv
module test_spiwin_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [25:0] rdAddr = '0;
  logic        rdReq = 1'b0;
  logic        rdReady;
  logic [7:0]  rdData;
  logic [7:0]  totalUnits = 8'd128;
  logic [5:0]  devUnits = 6'd32;
  logic [1:0]  burstCfg = 2'd0;
  logic        stallHost = 1'b0;
  logic        sclk;
  logic [3:0]  csN;
  logic        mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  spiwin_top i_spiwin_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memByte(int cs, int a);
    return 8'((a * 13) ^ (a >> 8) ^ (cs * 91) ^ (a >> 16));
  endfunction

  // behavioural flash devices sharing the bus
  int rxCnt = 0, txCnt = 0, txnCount = 0, capCs = 0;
  logic [31:0] rxShift = '0;
  logic [7:0]  capOp = '0;
  logic [23:0] capAddr = '0;

  always @(csN) if (csN == 4'hf) begin rxCnt = 0; txCnt = 0; end

  always @(posedge sclk) if (csN != 4'hf) begin
    if (rxCnt == 0) begin
      txnCount++;
      for (int k = 0; k < 4; k++) if (!csN[k]) capCs = k;
    end
    if (rxCnt < 32) rxShift = {rxShift[30:0], mosi};
    rxCnt++;
    if (rxCnt == 32) begin capOp = rxShift[31:24]; capAddr = rxShift[23:0]; end
  end

  always @(negedge sclk) if (csN != 4'hf && rxCnt >= 32) begin
    logic [7:0] b;
    b = memByte(capCs, int'(capAddr) + txCnt / 8);
    miso = b[7 - (txCnt % 8)];
    txCnt++;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock bus monitor
  int overlapErr = 0, sclkErr = 0, gapErr = 0, highRun = 2;
  always @(negedge clk) if (rstN) begin
    if ($countones(~csN) > 1) overlapErr++;
    if (csN == 4'hf && sclk) sclkErr++;
    if (csN == 4'hf) highRun++;
    else begin
      if (highRun != 0 && highRun < 2) gapErr++;
      highRun = 0;
    end
  end

  // reference line state
  bit modelValid = 0;
  int modelTag = 0;

  task automatic doRead(input logic [25:0] a, input string req);
    int expLat, expTxn, n, t0;
    logic [7:0] expData;
    bit inR, burst, hit;
    logic [23:0] expAddr;
    inR = ((a >> 19) < totalUnits) && ((a[23:0] >> 19) < devUnits);
    burst = (burstCfg == 2'd3);
    hit = burst && modelValid && (modelTag == int'(a >> 4));
    expData = inR ? memByte(int'(a[25:24]), int'(a[23:0])) : 8'h00;
    if (!inR || hit) begin expLat = 1; expTxn = 0; end
    else if (burst) begin expLat = 322; expTxn = 1; modelValid = 1; modelTag = int'(a >> 4); end
    else begin expLat = 82; expTxn = 1; end
    expAddr = burst ? {a[23:4], 4'h0} : a[23:0];
    t0 = txnCount;
    @(negedge clk); rdAddr = a; rdReq = 1'b1; n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!rdReady && n < 2000);
    rdReq = 1'b0;
    check(rdData == expData, req, "data", rdData, expData);
    check(n == expLat, req, "latency", n, expLat);
    check(txnCount - t0 == expTxn, req, "transactions", txnCount - t0, expTxn);
    if (expTxn == 1) begin
      check(capOp == 8'h03, "R1", "opcode", capOp, 8'h03);
      check(capAddr == expAddr, req, "flash address", capAddr, expAddr);
      check(capCs == int'(a[25:24]), "R1", "chip select", capCs, a[25:24]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(csN == 4'hf, "R9", "csN after reset", csN, 4'hf);
    check(sclk == 1'b0 && rdReady == 1'b0, "R9", "sclk/ready after reset", {sclk, rdReady}, 0);

    // R1 R6 single reads in several slots
    doRead(26'h0000123, "R6");
    doRead(26'h2ABCDE0, "R1");
    doRead(26'h3FFFFFF, "R1");

    // R4 R5 burst fill and hits (first fill after reset is a miss: R9)
    burstCfg = 2'd3;
    doRead(26'h1000047, "R9");
    doRead(26'h100004C, "R5");
    doRead(26'h1000040, "R5");
    doRead(26'h1000050, "R4");
    doRead(26'h0000050, "R4");
    doRead(26'h1000047, "R4");
    // R6 buffered line ignored without burst setting
    burstCfg = 2'd1;
    doRead(26'h1000047, "R6");
    burstCfg = 2'd3;
    doRead(26'h1000048, "R5");

    // R3 range limits
    burstCfg = 2'd0;
    totalUnits = 8'd100; devUnits = 6'd8;
    doRead(26'h31FFFFF - 26'h1C00000, "R3");
    doRead(26'h3200000, "R3");
    doRead(26'h03FFFFF, "R3");
    doRead(26'h0400000, "R3");
    doRead(26'h0500000, "R3");
    totalUnits = 8'd128; devUnits = 6'd32;

    // R7 stall holds the request off
    begin
      int t0, n, bad;
      t0 = txnCount; bad = 0;
      @(negedge clk); stallHost = 1'b1; rdAddr = 26'h0000200; rdReq = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (rdReady || csN != 4'hf) bad++;
      end
      check(bad == 0, "R7", "activity while stalled", bad, 0);
      check(txnCount == t0, "R7", "transactions while stalled", txnCount - t0, 0);
      stallHost = 1'b0; n = 0;
      do begin @(posedge clk); n++; @(negedge clk); end while (!rdReady && n < 2000);
      rdReq = 1'b0;
      check(n == 82, "R7", "latency after release", n, 82);
      check(rdData == memByte(0, 'h200), "R7", "data after release", rdData, memByte(0, 'h200));
    end

    repeat (4) @(negedge clk);
    check(overlapErr == 0, "R8", "overlapping selects", overlapErr, 0);
    check(gapErr == 0, "R8", "short deselect gap", gapErr, 0);
    check(sclkErr == 0, "R2", "sclk high while deselected", sclkErr, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule